// File: doc/BRIEF.md
# Programmable Video Sync Output Generator

The block rebuilds the horizontal (HS) and vertical (VS) sync outputs of an interlaced standard-definition video stream from a reference sync. A pixel counter restarts on every falling edge of the active-low reference HSYNC. The HS output is placed by two 11-bit pixel offsets from that edge. The first offset sets where the pulse starts and the second sets where it stops, so software chooses both its position and its width. The line number and the field flag are captured at the same edge.

VS rises on a programmed begin line and falls on a programmed end line. In the default mode both VS edges fall on pixel 0 of the line. In manual mode, each VS edge is placed either at a "start of line" point or at mid-line, chosen separately for each edge and each field. The start-of-line point is HS begin or HS end, as selected. Mid-line is that point plus half of a programmed line length.

Software writes byte-wide registers, which go into a staging copy. The staging copy becomes active only at the next reference falling edge, so a pulse is never cut by a write in the middle of a line.

Top module: `sync_regen`

## Requirements
- R1: While rst_n is low at a clock edge, hs_out and vs_out are 0 after that edge.
- R2: HS begin has the value B. When the active values are in force on a line, hs_out becomes 1 at the clock edge that is B+1 edges after the edge that first samples ref_hsync_n low.
- R3: HS end has the value E. hs_out becomes 0 at the clock edge that is E+1 edges after that same edge.
- R4: When E < B, the HS pulse carries across the next reference falling edge and ends at pixel E of the following line.
- R5: When E == B, the end wins and no HS pulse is produced.
- R6: The registers are written with wr_en, wr_addr and wr_data, one byte per write. The address map is:
  - Address 0 holds the low 8 bits of B, and address 1 bits [2:0] hold its upper 3 bits.
  - Addresses 2 and 3 hold E in the same way.
  - Addresses 4 and 5 hold the line length L in the same way.
  - Addresses 6 and 7 bits [1:0] hold the 10-bit VS begin line.
  - Addresses 8 and 9 bits [1:0] hold the 10-bit VS end line.
  - Address 10 is the mode register.
- R7: A write changes only the staging copy. Outputs follow the new values only from the next reference falling edge on.
- R8: Mode bit 0 is manual enable. When it is 0, VS becomes 1 one edge after pixel 0 of the VS begin line, and becomes 0 one edge after pixel 0 of the VS end line. The line number is sampled on line_num at the reference falling edge.
- R9: Manual mode places each VS edge at the start-of-line point S when its bit is 1, or at mid-line when its bit is 0. Mid-line is (S + floor(L/2)) mod 2048. The output changes one edge after that pixel.
- R10: Mode bit 1 selects the start-of-line point. When it is 1, S = B. When it is 0, S = E.
- R11: The placement bits act per field. Bit 2 is rise in even fields and bit 3 is rise in odd fields. Bit 4 is fall in even fields and bit 5 is fall in odd fields. field_odd is 1 for an odd field and is sampled at the reference falling edge. On a line and pixel where both VS edges fall, the fall wins.
- R12: Reset is synchronous. Asserting rst_n in the middle of a line clears all registers and counters. After reset, outputs stay 0 until new values are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_hsync_n | input | 1 | Reference HSYNC, active low; falling edge marks pixel 0 |
| field_odd | input | 1 | Field flag, 1 = odd field |
| line_num | input | 10 | Current line number, sampled at the reference falling edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| hs_out | output | 1 | Regenerated HS |
| vs_out | output | 1 | Regenerated VS |

## Verification
The hardest case to reach is a register update that lands while a wrapped HS pulse is high across a line boundary. In that case the pulse that is still running must end at the new end offset, not at the old one. The stimulus first programs an end offset below the begin offset. During a line, after the pulse has started, it writes a non-wrapping pair. The reference model then checks every clock across the following reference edge. Per-field VS placement is covered by running one frame in each field under several mode bytes.

// File: rtl/sync_regen_pkg.sv
// Shared widths, register map and the configuration record of the sync generator.
// Assumes byte-wide register writes and an 11-bit pixel count per line.
package sync_regen_pkg;
    localparam int PIX_W  = 11;
    localparam int LINE_W = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int PHI_W  = PIX_W - DATA_W;
    localparam int LHI_W  = LINE_W - DATA_W;

    localparam logic [ADDR_W-1:0] A_HSB_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_HSB_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_HSE_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_HSE_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_LEN_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_LEN_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_VSB_LO = 4'd6;
    localparam logic [ADDR_W-1:0] A_VSB_HI = 4'd7;
    localparam logic [ADDR_W-1:0] A_VSE_LO = 4'd8;
    localparam logic [ADDR_W-1:0] A_VSE_HI = 4'd9;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'd10;

    typedef struct packed {
        logic [PIX_W-1:0]  hsb;
        logic [PIX_W-1:0]  hse;
        logic [PIX_W-1:0]  line_len;
        logic [LINE_W-1:0] vs_bl;
        logic [LINE_W-1:0] vs_el;
        logic              manual_en;
        logic              ref_hsb;
        logic              rise_even_sol;
        logic              rise_odd_sol;
        logic              fall_even_sol;
        logic              fall_odd_sol;
    } cfg_t;
endpackage

// File: rtl/sync_regen_regs.sv
// Staging and active register copies.
// Writes land in staging; the active copy is reloaded only on the apply strobe
// (reference falling edge), so outputs never see a half-written setting.
module sync_regen_regs
    import sync_regen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              apply,
    output cfg_t              act_cfg
);
    cfg_t stg;

    // Byte writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_HSB_LO: stg.hsb[DATA_W-1:0]          <= wr_data;
                A_HSB_HI: stg.hsb[PIX_W-1:DATA_W]      <= wr_data[PHI_W-1:0];
                A_HSE_LO: stg.hse[DATA_W-1:0]          <= wr_data;
                A_HSE_HI: stg.hse[PIX_W-1:DATA_W]      <= wr_data[PHI_W-1:0];
                A_LEN_LO: stg.line_len[DATA_W-1:0]     <= wr_data;
                A_LEN_HI: stg.line_len[PIX_W-1:DATA_W] <= wr_data[PHI_W-1:0];
                A_VSB_LO: stg.vs_bl[DATA_W-1:0]        <= wr_data;
                A_VSB_HI: stg.vs_bl[LINE_W-1:DATA_W]   <= wr_data[LHI_W-1:0];
                A_VSE_LO: stg.vs_el[DATA_W-1:0]        <= wr_data;
                A_VSE_HI: stg.vs_el[LINE_W-1:DATA_W]   <= wr_data[LHI_W-1:0];
                A_MODE: begin
                    stg.manual_en     <= wr_data[0];
                    stg.ref_hsb       <= wr_data[1];
                    stg.rise_even_sol <= wr_data[2];
                    stg.rise_odd_sol  <= wr_data[3];
                    stg.fall_even_sol <= wr_data[4];
                    stg.fall_odd_sol  <= wr_data[5];
                end
                default: ;
            endcase
        end
    end

    // Transfer staging to active at the line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     act_cfg <= '0;
        else if (apply) act_cfg <= stg;
    end
endmodule

// File: rtl/sync_regen_timebase.sv
// Reference edge detector and pixel counter.
// Assumes ref_hsync_n is synchronous to clk and idles high. Pixel 0 is the cycle
// after the edge that first samples it low; the count saturates at its maximum.
module sync_regen_timebase
    import sync_regen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_hsync_n,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] line_num,
    output logic              ref_fall,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic              pix_valid,
    output logic [LINE_W-1:0] line_q,
    output logic              field_q
);
    logic ref_d;

    assign ref_fall = ref_d & ~ref_hsync_n;

    // Restart the count and capture line/field on each reference falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d     <= 1'b1;
            pix_cnt   <= '0;
            pix_valid <= 1'b0;
            line_q    <= '0;
            field_q   <= 1'b0;
        end else begin
            ref_d <= ref_hsync_n;
            if (ref_fall) begin
                pix_cnt   <= '0;
                pix_valid <= 1'b1;
                line_q    <= line_num;
                field_q   <= field_odd;
            end else if (pix_valid && (pix_cnt != '1)) begin
                pix_cnt <= pix_cnt + PIX_W'(1);
            end
        end
    end
endmodule

// File: rtl/sync_regen_hs.sv
// HS pulse former: set at the begin offset, clear at the end offset.
// The state simply holds between hits, which makes a pulse with end < begin
// wrap across the line boundary; when both hit together the clear wins.
module sync_regen_hs
    import sync_regen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_cnt,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] hsb,
    input  logic [PIX_W-1:0] hse,
    output logic             hs_q
);
    logic begin_hit, end_hit;

    assign begin_hit = pix_valid && (pix_cnt == hsb);
    assign end_hit   = pix_valid && (pix_cnt == hse);

    // Set/clear register for the HS output.
    always_ff @(posedge clk) begin
        if (!rst_n)         hs_q <= 1'b0;
        else if (end_hit)   hs_q <= 1'b0;
        else if (begin_hit) hs_q <= 1'b1;
    end
endmodule

// File: rtl/sync_regen_vs.sv
// VS edge placer: rises on the begin line, falls on the end line, each at pixel 0
// (default mode) or at start-of-line / mid-line chosen per edge and per field.
// Assumes start-of-line plus half the line length fits inside the line.
module sync_regen_vs
    import sync_regen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic              pix_valid,
    input  logic [LINE_W-1:0] line_q,
    input  logic              field_q,
    input  cfg_t              cfg,
    output logic              vs_q
);
    logic [PIX_W-1:0] sol_pos, mid_pos, rise_pos, fall_pos;
    logic             rise_sol, fall_sol, rise_hit, fall_hit;

    // Pick the transition pixel for each edge from mode, field and reference.
    always_comb begin
        sol_pos  = cfg.ref_hsb ? cfg.hsb : cfg.hse;
        mid_pos  = sol_pos + (cfg.line_len >> 1);
        rise_sol = field_q ? cfg.rise_odd_sol : cfg.rise_even_sol;
        fall_sol = field_q ? cfg.fall_odd_sol : cfg.fall_even_sol;
        rise_pos = cfg.manual_en ? (rise_sol ? sol_pos : mid_pos) : '0;
        fall_pos = cfg.manual_en ? (fall_sol ? sol_pos : mid_pos) : '0;
        rise_hit = pix_valid && (line_q == cfg.vs_bl) && (pix_cnt == rise_pos);
        fall_hit = pix_valid && (line_q == cfg.vs_el) && (pix_cnt == fall_pos);
    end

    // Set/clear register for the VS output.
    always_ff @(posedge clk) begin
        if (!rst_n)        vs_q <= 1'b0;
        else if (fall_hit) vs_q <= 1'b0;
        else if (rise_hit) vs_q <= 1'b1;
    end
endmodule

// File: rtl/sync_regen.sv
// Top of the programmable sync output generator: registers, time base and the two
// output formers. Inputs are assumed synchronous to the pixel clock.
module sync_regen
    import sync_regen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_hsync_n,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] line_num,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hs_out,
    output logic              vs_out
);
    cfg_t              act_cfg;
    logic              ref_fall;
    logic [PIX_W-1:0]  pix_cnt;
    logic              pix_valid;
    logic [LINE_W-1:0] line_q;
    logic              field_q;

    sync_regen_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .apply(ref_fall), .act_cfg(act_cfg)
    );

    sync_regen_timebase u_tb (
        .clk(clk), .rst_n(rst_n), .ref_hsync_n(ref_hsync_n), .field_odd(field_odd),
        .line_num(line_num), .ref_fall(ref_fall), .pix_cnt(pix_cnt),
        .pix_valid(pix_valid), .line_q(line_q), .field_q(field_q)
    );

    sync_regen_hs u_hs (
        .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .pix_valid(pix_valid),
        .hsb(act_cfg.hsb), .hse(act_cfg.hse), .hs_q(hs_out)
    );

    sync_regen_vs u_vs (
        .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .pix_valid(pix_valid),
        .line_q(line_q), .field_q(field_q), .cfg(act_cfg), .vs_q(vs_out)
    );
endmodule

// File: rtl/sync_regen_checker.sv
// Property checker for sync_regen, attached by bind. Relates output edges to the
// time base and active settings, and the active settings to the reference edge.
module sync_regen_checker
    import sync_regen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hs_out,
    input logic              vs_out,
    input logic              ref_fall,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic              pix_valid,
    input logic [LINE_W-1:0] line_q,
    input cfg_t              act_cfg
);
    // R1 / R12: reset drives both outputs inactive.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!hs_out && !vs_out));

    // R2: HS only rises after the begin offset was reached.
    assert_hs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_out) |-> ($past(pix_valid) && ($past(pix_cnt) == $past(act_cfg.hsb))));

    // R3: HS only falls after the end offset was reached.
    assert_hs_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_out) |-> ($past(pix_valid) && ($past(pix_cnt) == $past(act_cfg.hse))));

    // R5: equal offsets leave HS low.
    assert_equal_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (pix_cnt == act_cfg.hsb) && (act_cfg.hsb == act_cfg.hse)) |=> !hs_out);

    // R7: active settings change only at a reference falling edge.
    assert_shadow_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> $past(ref_fall));

    // R8: VS rises only on the programmed begin line.
    assert_vs_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_out) |-> ($past(line_q) == $past(act_cfg.vs_bl)));
endmodule

bind sync_regen sync_regen_checker u_checker (
    .clk(clk), .rst_n(rst_n), .hs_out(hs_out), .vs_out(vs_out),
    .ref_fall(ref_fall), .pix_cnt(pix_cnt), .pix_valid(pix_valid),
    .line_q(line_q), .act_cfg(act_cfg)
);

// File: tb/sync_regen_bench.sv
// Bench for sync_regen: behavioural reference model stepped on every clock and
// compared with the outputs on every falling clock edge.
module sync_regen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_hsync_n = 1'b1;
    logic       field_odd = 1'b0;
    logic [9:0] line_num = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       hs_out, vs_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    armed = 1'b0;

    int s_reg[11];
    int a_reg[11];
    int m_ref_d, m_pix, m_valid, m_line, m_field;
    bit m_hs, m_vs;

    always #4 clk = ~clk;

    sync_regen u_sync_regen (
        .clk(clk), .rst_n(rst_n), .ref_hsync_n(ref_hsync_n), .field_odd(field_odd),
        .line_num(line_num), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hs_out(hs_out), .vs_out(vs_out)
    );

    function automatic int joined(int lo, int hi, int mask);
        return lo | ((hi & mask) << 8);
    endfunction

    // Reference model, one step per rising clock edge.
    always @(posedge clk) begin : model
        int hsb, hse, len, vbl, vel, mode, sol, mid, rp, fp;
        bit rs, fs, rhit, fhit;
        if (!rst_n) begin
            for (int i = 0; i < 11; i++) begin s_reg[i] = 0; a_reg[i] = 0; end
            m_ref_d = 1; m_pix = 0; m_valid = 0; m_line = 0; m_field = 0;
            m_hs = 0; m_vs = 0;
        end else begin
            hsb  = joined(a_reg[0], a_reg[1], 7);
            hse  = joined(a_reg[2], a_reg[3], 7);
            len  = joined(a_reg[4], a_reg[5], 7);
            vbl  = joined(a_reg[6], a_reg[7], 3);
            vel  = joined(a_reg[8], a_reg[9], 3);
            mode = a_reg[10];
            if (m_valid != 0 && m_pix == hse)      m_hs = 0;
            else if (m_valid != 0 && m_pix == hsb) m_hs = 1;
            sol = mode[1] ? hsb : hse;
            mid = (sol + len / 2) % 2048;
            rs  = m_field != 0 ? mode[3] : mode[2];
            fs  = m_field != 0 ? mode[5] : mode[4];
            rp  = mode[0] ? (rs ? sol : mid) : 0;
            fp  = mode[0] ? (fs ? sol : mid) : 0;
            rhit = (m_valid != 0) && (m_line == vbl) && (m_pix == rp);
            fhit = (m_valid != 0) && (m_line == vel) && (m_pix == fp);
            if (fhit)      m_vs = 0;
            else if (rhit) m_vs = 1;
            if (m_ref_d != 0 && ref_hsync_n == 1'b0) begin
                for (int i = 0; i < 11; i++) a_reg[i] = s_reg[i];
                m_pix = 0; m_valid = 1; m_line = line_num; m_field = field_odd;
            end else if (m_valid != 0 && m_pix < 2047) begin
                m_pix = m_pix + 1;
            end
            if (wr_en && wr_addr < 11) s_reg[wr_addr] = wr_data;
            m_ref_d = ref_hsync_n;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            n_cmp++;
            if (hs_out !== m_hs || vs_out !== m_vs) begin
                n_bad++;
                $display("FAIL %s: hs_out=%0b vs_out=%0b expected hs=%0b vs=%0b at %0t",
                         cur_req, hs_out, vs_out, m_hs, m_vs, $time);
            end
        end
    end

    task automatic check_idle(input string req);
        n_cmp++;
        if (hs_out !== 1'b0 || vs_out !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: hs_out=%0b vs_out=%0b expected hs=0 vs=0", req, hs_out, vs_out);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic begin_line(input int ln, input bit fld);
        line_num = 10'(ln); field_odd = fld; ref_hsync_n = 1'b0;
        idle(4);
        ref_hsync_n = 1'b1;
    endtask

    task automatic run_frame(input bit fld);
        for (int l = 0; l < 9; l++) begin
            begin_line(l, fld);
            idle(396);
        end
    endtask

    task automatic set_hs(input int b, input int e);
        wr(0, b & 255); wr(1, b >> 8); wr(2, e & 255); wr(3, e >> 8);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin : stimulus
        @(posedge clk);
        armed = 1'b1;
        idle(4);
        check_idle("R1");
        rst_n = 1'b1;

        // R6: program offsets, line length 400, VS lines 3..6, default mode.
        cur_req = "R6";
        set_hs(20, 60);
        wr(4, 400 & 255); wr(5, 400 >> 8);
        wr(6, 3); wr(7, 0); wr(8, 6); wr(9, 0); wr(10, 0);
        cur_req = "R2";
        run_frame(1'b0);

        // R7: mid-line write with upper offset bits; effective on the next line.
        cur_req = "R7";
        begin_line(0, 1'b0);
        idle(30);
        set_hs(300, 350);
        idle(340);
        cur_req = "R3";
        run_frame(1'b0);

        // R4: wrapped pulse, then a change written while the wrapped pulse is high.
        cur_req = "R4";
        set_hs(350, 30);
        run_frame(1'b0);
        begin_line(0, 1'b0);
        idle(360);
        set_hs(100, 200);
        idle(28);
        run_frame(1'b0);

        // R5: equal offsets give no pulse.
        cur_req = "R5";
        set_hs(100, 100);
        run_frame(1'b0);

        // R8: default VS timing on both fields.
        cur_req = "R8";
        set_hs(20, 60);
        run_frame(1'b0);
        run_frame(1'b1);

        // R9: manual, mid-line placement relative to HS end.
        cur_req = "R9";
        wr(10, 8'h01);
        run_frame(1'b0);
        wr(10, 8'h3D);
        run_frame(1'b1);

        // R10: start-of-line reference switched to HS begin.
        cur_req = "R10";
        wr(10, 8'h03);
        run_frame(1'b0);
        wr(10, 8'h3F);
        run_frame(1'b0);

        // R11: per-field placement bits.
        cur_req = "R11";
        wr(10, 8'h25);
        run_frame(1'b0);
        run_frame(1'b1);
        wr(10, 8'h19);
        run_frame(1'b0);
        run_frame(1'b1);
        wr(6, 4); wr(8, 4);
        run_frame(1'b0);

        // R12: synchronous reset in the middle of a VS-high stretch.
        cur_req = "R12";
        wr(6, 2); wr(8, 6); wr(10, 8'h00);
        for (int l = 0; l < 4; l++) begin begin_line(l, 1'b0); idle(396); end
        begin_line(4, 1'b0);
        idle(40);
        rst_n = 1'b0;
        idle(3);
        check_idle("R12");
        rst_n = 1'b1;
        run_frame(1'b0);
        check_idle("R12");

        report();
    end
endmodule